// File: doc/BRIEF.md
# Burst Write Bus Handshake (Initiator with Claiming Target)

This block moves a burst of words from a local producer onto a shared multiplexed address/data bus, and includes a simple target that claims the burst and captures each word. A local client presents a start address and a beat count. The initiator then drives one address cycle carrying the write command, followed by as many data phases as the count asks for. The bus control lines are all active-low. The initiator owns the frame and initiator-ready lines. The target owns the device-select and target-ready lines. The address/data lines are shared, and in a write only the initiator drives them.

Each side has its own ready input. The producer's word-valid flag drives initiator-ready, and the target's own ready input drives target-ready. A data phase completes only on a clock edge where both are asserted, so either party can stretch any beat by any number of wait states. If the target never claims the transfer within a parameterised window, the initiator abandons the burst and reports an error. Every transaction ends with one turnaround cycle before a new request is accepted.

Top module: `bwr_link`

## Requirements
- R1: After reset, frame_n, irdy_n, trdy_n and devsel_n are all high, req_ready is high, and xfer_done, xfer_err, cap_valid and feed_take are low.
- R2: In the cycle after a request is accepted (req_valid and req_ready high at a clock edge), the bus is in its address phase: frame_n is low, irdy_n is high, ad carries req_addr, and cbe_n carries the write command 4'b0111 in its low four bits.
- R3: A beat completes only at an edge where irdy_n and trdy_n are both low. feed_take is high in exactly those cycles of the data phase, and each beat consumes one feed word.
- R4: During a data phase irdy_n is the inverse of feed_valid, so a low feed_valid inserts an initiator wait state and ad carries feed_data.
- R5: trdy_n is low only while the target has claimed the burst and tgt_ready is high. A low tgt_ready inserts a target wait state.
- R6: One cycle after each completed beat, cap_valid is high with cap_data equal to the word transferred and cap_addr equal to the start address plus 4 times the beat index (starting at 0). cap_valid is low in all other cycles.
- R7: frame_n stays low during every data phase except the final one, and stays high throughout the final data phase. Bursts of 1 up to 2^LEN_W-1 beats are carried.
- R8: When tgt_en is high, the target drives devsel_n low from the first data-phase cycle and holds it low until the last beat completes.
- R9: If devsel_n is still high after DEVSEL_WAIT data-phase cycles (default 4), the initiator ends the burst. In the following cycle xfer_done and xfer_err are both high, and no beat or capture takes place.
- R10: The cycle after the last beat (or the abort) is a turnaround cycle. In it xfer_done is high, frame_n, irdy_n and devsel_n are high, and req_ready is low. req_ready returns high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local burst request |
| req_addr | input | DW | Burst start address |
| req_len | input | LEN_W | Number of beats (nonzero) |
| req_ready | output | 1 | Initiator idle, request accepted when both high |
| feed_valid | input | 1 | Producer word available (initiator ready) |
| feed_data | input | DW | Producer word |
| feed_take | output | 1 | Current word consumed at this edge |
| tgt_en | input | 1 | Target claims write bursts when high |
| tgt_ready | input | 1 | Target able to accept a word |
| frame_n | output | 1 | Bus frame, initiator-driven, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Target claims the burst, active low |
| ad | output | DW | Multiplexed address/data bus |
| cbe_n | output | DW/8 | Command in address phase, byte enables (all on) in data phase |
| cap_valid | output | 1 | Target captured a word |
| cap_addr | output | DW | Address of the captured word |
| cap_data | output | DW | Captured word |
| xfer_done | output | 1 | Turnaround cycle after a burst ends |
| xfer_err | output | 1 | Burst ended without a target claim |

## Verification
Three events can fall in the same cycle: the initiator's wait state, the target's wait state, and the final beat together with the deassertion of frame_n. The bench runs every burst length from one to four against every pairing of four periodic ready patterns on each side, at two phase offsets. This places the two sides' wait states both in step and out of step, and lands the last beat on cycles where both sides become ready together. From the two patterns alone, the bench works out the cycle in which each beat must complete, the state of frame_n in every phase, and the cycle of the turnaround. Every bus line and capture output is then compared against those predictions in every cycle.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_TURN = 2'd3
   } bwr_state_e;

   localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
endpackage

// File: rtl/bwr_initiator.sv
module bwr_initiator
   import bwr_pkg::*;
#(
   parameter int DW          = 32,
   parameter int LEN_W       = 4,
   parameter int DEVSEL_WAIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [DW-1:0]    req_addr,
   input  logic [LEN_W-1:0] req_len,
   output logic             req_ready,
   input  logic             feed_valid,
   input  logic [DW-1:0]    feed_data,
   output logic             feed_take,
   input  logic             devsel_n,
   input  logic             trdy_n,
   output logic             frame_n,
   output logic             irdy_n,
   output logic [DW-1:0]    ad_o,
   output logic [DW/8-1:0]  cbe_o,
   output logic             xfer_done,
   output logic             xfer_err
);
   localparam int CW = DW / 8;

   bwr_state_e       state_q;
   logic [DW-1:0]    addr_q;
   logic [LEN_W-1:0] left_q;
   logic             err_q;
   logic             abort;
   logic             beat;
   logic             last;

   assign last = (left_q == LEN_W'(1));
   assign beat = (state_q == ST_DATA) && feed_valid && !trdy_n;

   generate
      if (DEVSEL_WAIT > 0) begin : g_timeout
         localparam int WW = $clog2(DEVSEL_WAIT + 1);
         logic [WW-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wait_q <= '0;
            end else if (state_q == ST_ADDR) begin
               wait_q <= '0;
            end else if (state_q == ST_DATA && devsel_n && wait_q != WW'(DEVSEL_WAIT - 1)) begin
               wait_q <= wait_q + WW'(1);
            end
         end
         assign abort = (state_q == ST_DATA) && devsel_n && (wait_q == WW'(DEVSEL_WAIT - 1));
      end else begin : g_no_timeout
         assign abort = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_ADDR;
                  addr_q  <= req_addr;
                  left_q  <= req_len;
                  err_q   <= 1'b0;
               end
            end
            ST_ADDR: state_q <= ST_DATA;
            ST_DATA: begin
               if (abort) begin
                  state_q <= ST_TURN;
                  err_q   <= 1'b1;
               end else if (beat) begin
                  if (last) state_q <= ST_TURN;
                  left_q <= left_q - LEN_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign feed_take = beat;
   assign frame_n   = !((state_q == ST_ADDR) || (state_q == ST_DATA && !last));
   assign irdy_n    = !((state_q == ST_DATA) && feed_valid);
   assign ad_o      = (state_q == ST_ADDR) ? addr_q :
                      (state_q == ST_DATA) ? feed_data : '0;
   assign cbe_o     = (state_q == ST_ADDR) ? CW'(CMD_MEM_WRITE) : '0;
   assign xfer_done = (state_q == ST_TURN);
   assign xfer_err  = err_q;

   // R9
   no_beat_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && devsel_n) |-> !feed_take);

   // R7
   last_beat_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_take && frame_n) |=> (state_q == ST_TURN));

   // R8
   devsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && !devsel_n && !(feed_take && frame_n)) |=> !devsel_n);

   // R7
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (req_len != '0));
endmodule

// File: rtl/bwr_target.sv
module bwr_target
   import bwr_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tgt_en,
   input  logic            tgt_ready,
   input  logic            frame_n,
   input  logic            irdy_n,
   input  logic [DW-1:0]   ad,
   input  logic [DW/8-1:0] cbe_n,
   output logic            devsel_n,
   output logic            trdy_n,
   output logic            cap_valid,
   output logic [DW-1:0]   cap_addr,
   output logic [DW-1:0]   cap_data
);
   localparam int BYTES = DW / 8;

   logic          sel_q;
   logic          frame_prev_q;
   logic [DW-1:0] addr_q;
   logic          addr_phase;
   logic          beat;

   assign addr_phase = !frame_n && frame_prev_q && !sel_q && tgt_en &&
                       (cbe_n[3:0] == CMD_MEM_WRITE);
   assign beat       = sel_q && !irdy_n && !trdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q        <= 1'b0;
         frame_prev_q <= 1'b1;
         addr_q       <= '0;
         cap_valid    <= 1'b0;
         cap_addr     <= '0;
         cap_data     <= '0;
      end else begin
         frame_prev_q <= frame_n;
         cap_valid    <= beat;
         if (addr_phase) begin
            sel_q  <= 1'b1;
            addr_q <= ad;
         end else if (beat) begin
            cap_addr <= addr_q;
            cap_data <= ad;
            addr_q   <= addr_q + DW'(BYTES);
            if (frame_n) sel_q <= 1'b0;
         end
      end
   end

   assign devsel_n = !sel_q;
   assign trdy_n   = !(sel_q && tgt_ready);

   // R6
   cap_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> $past(!irdy_n && !trdy_n));

   // R10
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && !trdy_n && frame_n) |=> devsel_n);

   // R2
   addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n) |-> irdy_n);
endmodule

// File: rtl/bwr_link.sv
module bwr_link
   import bwr_pkg::*;
#(
   parameter int DW          = 32,
   parameter int LEN_W       = 4,
   parameter int DEVSEL_WAIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [DW-1:0]    req_addr,
   input  logic [LEN_W-1:0] req_len,
   output logic             req_ready,
   input  logic             feed_valid,
   input  logic [DW-1:0]    feed_data,
   output logic             feed_take,
   input  logic             tgt_en,
   input  logic             tgt_ready,
   output logic             frame_n,
   output logic             irdy_n,
   output logic             trdy_n,
   output logic             devsel_n,
   output logic [DW-1:0]    ad,
   output logic [DW/8-1:0]  cbe_n,
   output logic             cap_valid,
   output logic [DW-1:0]    cap_addr,
   output logic [DW-1:0]    cap_data,
   output logic             xfer_done,
   output logic             xfer_err
);
   generate
      if (DW % 8 != 0 || DW < 32) begin : g_bad_dw
         $error("bwr_link: DW must be a multiple of 8 and at least 32");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("bwr_link: LEN_W must be at least 2");
      end
      if (DEVSEL_WAIT < 0) begin : g_bad_wait
         $error("bwr_link: DEVSEL_WAIT must not be negative");
      end
   endgenerate

   bwr_initiator #(.DW(DW), .LEN_W(LEN_W), .DEVSEL_WAIT(DEVSEL_WAIT)) u_init (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_ready  (req_ready),
      .feed_valid (feed_valid),
      .feed_data  (feed_data),
      .feed_take  (feed_take),
      .devsel_n   (devsel_n),
      .trdy_n     (trdy_n),
      .frame_n    (frame_n),
      .irdy_n     (irdy_n),
      .ad_o       (ad),
      .cbe_o      (cbe_n),
      .xfer_done  (xfer_done),
      .xfer_err   (xfer_err)
   );

   bwr_target #(.DW(DW)) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt_en    (tgt_en),
      .tgt_ready (tgt_ready),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .ad        (ad),
      .cbe_n     (cbe_n),
      .devsel_n  (devsel_n),
      .trdy_n    (trdy_n),
      .cap_valid (cap_valid),
      .cap_addr  (cap_addr),
      .cap_data  (cap_data)
   );
endmodule

// File: tb/test_bwr_link.sv
`timescale 1ns/1ps
module test_bwr_link;
   localparam int DW = 32;
   localparam int LW = 4;
   localparam int WT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [DW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_ready;
   logic          feed_valid = 1'b0;
   logic [DW-1:0] feed_data = '0;
   logic          feed_take;
   logic          tgt_en = 1'b1;
   logic          tgt_ready = 1'b0;
   logic          frame_n, irdy_n, trdy_n, devsel_n;
   logic [DW-1:0] ad;
   logic [3:0]    cbe_n;
   logic          cap_valid;
   logic [DW-1:0] cap_addr, cap_data;
   logic          xfer_done, xfer_err;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit fin = 0;

   always #10 clk = ~clk;

   bwr_link #(.DW(DW), .LEN_W(LW), .DEVSEL_WAIT(WT)) i_bwr_link (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .req_ready(req_ready), .feed_valid(feed_valid),
      .feed_data(feed_data), .feed_take(feed_take), .tgt_en(tgt_en),
      .tgt_ready(tgt_ready), .frame_n(frame_n), .irdy_n(irdy_n),
      .trdy_n(trdy_n), .devsel_n(devsel_n), .ad(ad), .cbe_n(cbe_n),
      .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data),
      .xfer_done(xfer_done), .xfer_err(xfer_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit pat(input int mode, input int k, input int s);
      case (mode)
         0:       return 1'b1;
         1:       return ((k + s) % 2) != 0;
         2:       return ((k + s) % 3) != 0;
         default: return ((k + s) % 4) == 3;
      endcase
   endfunction

   function automatic logic [31:0] word(input int t, input int i);
      return {t[15:0], i[15:0]} ^ 32'hA5A5_0000;
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      fin = 1;
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !fin) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   task automatic burst(input int len, input int im, input int tm, input int s, input int t);
      logic [31:0] a0;
      int done_b, k, pidx;
      bit prev, iv, tr;
      a0 = 32'h1000_0000 + t * 64;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a0; req_len = LW'(len);
      feed_valid = 1'b0; tgt_ready = 1'b0;
      #1 chk("R10 req_ready idle", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R2 frame_n addr", {31'd0, frame_n}, 32'd0);
      chk("R2 irdy_n addr", {31'd0, irdy_n}, 32'd1);
      chk("R2 ad addr", ad, a0);
      chk("R2 cbe_n cmd", {28'd0, cbe_n}, 32'h7);
      done_b = 0; k = 0; prev = 0; pidx = 0;
      while (done_b < len) begin
         @(negedge clk);
         iv = pat(im, k, s); tr = pat(tm, k, s);
         feed_valid = iv; tgt_ready = tr; feed_data = word(t, done_b);
         #1;
         chk("R8 devsel_n data", {31'd0, devsel_n}, 32'd0);
         chk("R4 irdy_n", {31'd0, irdy_n}, {31'd0, !iv});
         chk("R4 ad data", ad, word(t, done_b));
         chk("R5 trdy_n", {31'd0, trdy_n}, {31'd0, !tr});
         chk("R7 frame_n data", {31'd0, frame_n}, {31'd0, done_b == len - 1});
         chk("R3 feed_take", {31'd0, feed_take}, {31'd0, iv && tr});
         chk("R6 cap_valid", {31'd0, cap_valid}, {31'd0, prev});
         if (prev) begin
            chk("R6 cap_addr", cap_addr, a0 + 4 * pidx);
            chk("R6 cap_data", cap_data, word(t, pidx));
         end
         if (iv && tr) begin prev = 1; pidx = done_b; done_b++; end
         else prev = 0;
         k++;
      end
      @(negedge clk);
      feed_valid = 1'b0; tgt_ready = 1'b0;
      #1;
      chk("R6 cap_valid last", {31'd0, cap_valid}, 32'd1);
      chk("R6 cap_addr last", cap_addr, a0 + 4 * pidx);
      chk("R6 cap_data last", cap_data, word(t, pidx));
      chk("R10 xfer_done", {31'd0, xfer_done}, 32'd1);
      chk("R10 xfer_err", {31'd0, xfer_err}, 32'd0);
      chk("R10 bus released", {29'd0, frame_n, irdy_n, devsel_n}, 32'h7);
      chk("R10 req_ready turn", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      #1;
      chk("R10 req_ready back", {31'd0, req_ready}, 32'd1);
      chk("R10 done clear", {31'd0, xfer_done}, 32'd0);
      chk("R6 cap_valid idle", {31'd0, cap_valid}, 32'd0);
   endtask

   initial begin
      int t;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 bus lines", {28'd0, frame_n, irdy_n, trdy_n, devsel_n}, 32'hF);
      chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1 outputs low", {28'd0, xfer_done, xfer_err, cap_valid, feed_take}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk("R1 after release", {28'd0, frame_n, irdy_n, trdy_n, devsel_n}, 32'hF);

      t = 0;
      for (int len = 1; len <= 4; len++)
         for (int im = 0; im < 4; im++)
            for (int tm = 0; tm < 4; tm++)
               for (int s = 0; s < 2; s++) begin
                  burst(len, im, tm, s, t);
                  t++;
               end
      burst(15, 0, 3, 0, t); t++;

      // R9: no target claims the burst
      tgt_en = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h2000_0000; req_len = LW'(3);
      @(negedge clk);
      req_valid = 1'b0; feed_valid = 1'b1; tgt_ready = 1'b1; feed_data = 32'hDEAD_BEEF;
      for (int k = 0; k < WT; k++) begin
         @(negedge clk);
         #1;
         chk("R9 devsel_n unclaimed", {31'd0, devsel_n}, 32'd1);
         chk("R9 no feed_take", {31'd0, feed_take}, 32'd0);
         chk("R9 no capture", {31'd0, cap_valid}, 32'd0);
         chk("R9 no done early", {31'd0, xfer_done}, 32'd0);
      end
      @(negedge clk);
      #1;
      chk("R9 xfer_done", {31'd0, xfer_done}, 32'd1);
      chk("R9 xfer_err", {31'd0, xfer_err}, 32'd1);
      chk("R9 cap_valid", {31'd0, cap_valid}, 32'd0);
      chk("R10 released after abort", {29'd0, frame_n, irdy_n, devsel_n}, 32'h7);
      feed_valid = 1'b0;
      @(negedge clk);
      #1 chk("R10 req_ready after abort", {31'd0, req_ready}, 32'd1);

      tgt_en = 1'b1;
      burst(3, 1, 2, 1, t);
      chk("R9 err cleared by new burst", {31'd0, xfer_err}, 32'd0);
      finish_run();
   end
endmodule